// File: doc/BRIEF.md
# Wrapped Line Fill Controller with Early Word Return

When a cache misses, this controller brings the whole line in from memory, but it asks for the missing word first. It sends one burst request that carries the exact word address of the miss. Memory then returns the line as a stream of words that wraps around inside the line: first the missed word, then each following word in turn, and past the last word of the line it continues from the first. The word the processor was waiting for goes back to the processor in the cycle it arrives, so execution resumes while the rest of the line is still being written into the data array.

Each beat from memory is written into the cache data array at its slot in the line. A bitmap records which slots already hold data. During the fill, the processor may ask for any word of the line. If the word has arrived, the controller serves it from its line buffer. If the word has not arrived, the processor stalls until that word comes in. The controller raises a one-cycle completion pulse after it writes the last word. It takes no new miss while a fill is running. Tags and the choice of victim are handled elsewhere.

Top module: `cwf_line_fill`

## Requirements
- R1: `miss_ready` is high when no fill is in progress. A miss is taken on a clock edge where `miss_valid` and `miss_ready` are both high. `miss_ready` then stays low until the cycle in which `fill_done` is high, and goes high again in that cycle.
- R2: In the cycle after a miss is taken, `mem_req_valid` rises and `mem_req_addr` equals the miss word address. Both hold steady until a clock edge where `mem_req_ready` is high.
- R3: `rd_ready` is high only from the cycle after the request is accepted until the eighth beat is taken. A `rd_valid` that comes outside that window causes no write and no other output change.
- R4: The k-th beat (k = 0..7) is written in its own cycle. In that cycle `wr_en` is 1, `wr_data` equals `rd_data`, and `wr_addr` keeps the upper bits of the miss address with its low 3 bits set to (miss offset + k) mod 8. No slot is written twice in one fill.
- R5: In the cycle of beat 0 only, `cpu_crit_valid` is 1 and `cpu_crit_data` equals `rd_data`.
- R6: During a fill, a processor read of line offset `cpu_rd_off` sees `cpu_rd_ready` high if that word was written by an earlier beat or arrives in the current beat. `cpu_rd_data` is then that word.
- R7: During a fill, a read of a word that has not yet arrived sees `cpu_rd_ready` low. Outside a fill, `cpu_rd_ready` is always low.
- R8: `fill_done` is high for exactly one cycle: the cycle right after the eighth write.
- R9: After reset, `miss_ready` is 1, and `mem_req_valid`, `rd_ready`, `wr_en`, `cpu_crit_valid`, `cpu_rd_ready` and `fill_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | 16 | Word address of the missing word |
| miss_ready | output | 1 | Controller idle, miss can be taken |
| mem_req_valid | output | 1 | Burst request to memory |
| mem_req_addr | output | 16 | Word address the burst starts at |
| mem_req_ready | input | 1 | Memory accepts the request |
| rd_valid | input | 1 | Memory word present |
| rd_data | input | 32 | Memory word |
| rd_ready | output | 1 | Controller takes memory words |
| wr_en | output | 1 | Write strobe to the data array |
| wr_addr | output | 16 | Data array word address |
| wr_data | output | 32 | Data array write word |
| cpu_crit_valid | output | 1 | Missed word returned to the processor |
| cpu_crit_data | output | 32 | The missed word |
| cpu_rd_valid | input | 1 | Processor reads a word of the line being filled |
| cpu_rd_off | input | 3 | Word offset of that read |
| cpu_rd_ready | output | 1 | Read served this cycle |
| cpu_rd_data | output | 32 | Read data |
| fill_done | output | 1 | One-cycle pulse when the line is complete |

## Verification
Fills start at offset 0, where nothing wraps, at a middle offset, and at offset 7, where every beat after the first wraps. This separates correct modulo slot placement from a line that is only written upward. Some runs have idle gaps between beats and a stalled request handshake, which shows that the slot counter advances only on accepted beats. A processor read parked on one offset shows both paths: the stall before its word arrives, and serving in the arrival cycle or later. Memory words presented while idle check that stray beats leave the data array untouched.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_FILL = 2'd2
  } fill_st_e;
endpackage

// File: rtl/cwf_wrap_seq.sv
module cwf_wrap_seq #(
  parameter int WORDS = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFF_W-1:0] start_off,
  input  logic             step,
  output logic [OFF_W-1:0] cur_off,
  output logic             first,
  output logic             last
);
  logic [OFF_W-1:0] cnt_q, cnt_n;
  logic [OFF_W-1:0] start_q, start_n;

  always_comb begin
    cnt_n   = cnt_q;
    start_n = start_q;
    if (load) begin
      cnt_n   = '0;
      start_n = start_off;
    end else if (step) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      start_q <= '0;
    end else begin
      cnt_q   <= cnt_n;
      start_q <= start_n;
    end
  end

  assign cur_off = start_q + cnt_q;
  assign first   = (cnt_q == '0);
  assign last    = (cnt_q == OFF_W'(WORDS - 1));

  AST_NO_STEP_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && step)); // R3
endmodule

// File: rtl/cwf_word_track.sv
module cwf_word_track #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  output logic              full
);
  logic [WORDS-1:0]  mask_q, mask_n;
  logic [DATA_W-1:0] buf_q [WORDS];

  always_comb begin
    mask_n = mask_q;
    if (clear) begin
      mask_n = '0;
    end else if (wr_en) begin
      mask_n[wr_off] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_n;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_off == OFF_W'(g))) buf_q[g] <= wr_data;
    end
  end

  logic fwd;
  assign fwd     = wr_en && (wr_off == rd_off);
  assign rd_hit  = mask_q[rd_off] || fwd;
  assign rd_data = fwd ? wr_data : buf_q[rd_off];
  assign full    = &mask_q;

  AST_NO_DOUBLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !mask_q[wr_off]); // R4
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill #(
  parameter int WORDS  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              miss_ready,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              cpu_crit_valid,
  output logic [DATA_W-1:0] cpu_crit_data,
  input  logic              cpu_rd_valid,
  input  logic [OFF_W-1:0]  cpu_rd_off,
  output logic              cpu_rd_ready,
  output logic [DATA_W-1:0] cpu_rd_data,
  output logic              fill_done
);
  import cwf_pkg::*;

  fill_st_e          st_q, st_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              done_q, done_n;
  logic              beat, start_fill;
  logic [OFF_W-1:0]  cur_off;
  logic              seq_first, seq_last;
  logic              trk_hit, trk_full;
  logic [DATA_W-1:0] trk_data;

  assign beat       = (st_q == ST_FILL) && rd_valid;
  assign start_fill = (st_q == ST_REQ) && mem_req_ready;

  always_comb begin
    st_n   = st_q;
    addr_n = addr_q;
    done_n = beat && seq_last;
    case (st_q)
      ST_IDLE: if (miss_valid) begin
        st_n   = ST_REQ;
        addr_n = miss_addr;
      end
      ST_REQ:  if (mem_req_ready) st_n = ST_FILL;
      ST_FILL: if (beat && seq_last) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      addr_q <= addr_n;
      done_q <= done_n;
    end
  end

  cwf_wrap_seq #(.WORDS(WORDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_fill),
    .start_off (addr_q[OFF_W-1:0]),
    .step      (beat),
    .cur_off   (cur_off),
    .first     (seq_first),
    .last      (seq_last)
  );

  cwf_word_track #(.WORDS(WORDS), .DATA_W(DATA_W)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_fill),
    .wr_en   (beat),
    .wr_off  (cur_off),
    .wr_data (rd_data),
    .rd_off  (cpu_rd_off),
    .rd_hit  (trk_hit),
    .rd_data (trk_data),
    .full    (trk_full)
  );

  assign miss_ready     = (st_q == ST_IDLE);
  assign mem_req_valid  = (st_q == ST_REQ);
  assign mem_req_addr   = addr_q;
  assign rd_ready       = (st_q == ST_FILL);
  assign wr_en          = beat;
  assign wr_addr        = {addr_q[ADDR_W-1:OFF_W], cur_off};
  assign wr_data        = rd_data;
  assign cpu_crit_valid = beat && seq_first;
  assign cpu_crit_data  = rd_data;
  assign cpu_rd_ready   = (st_q == ST_FILL) && trk_hit;
  assign cpu_rd_data    = trk_data;
  assign fill_done      = done_q;

  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready || mem_req_valid) |-> !miss_ready); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R2
  AST_CRIT_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_crit_valid |-> (wr_en && wr_addr == mem_req_addr)); // R5
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> ($past(wr_en) && trk_full)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_done); // R8
endmodule

// File: tb/sim_cwf_line_fill.sv
module sim_cwf_line_fill;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [15:0] miss_addr = '0;
  logic        miss_ready;
  logic        mem_req_valid;
  logic [15:0] mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        rd_ready;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic        cpu_crit_valid;
  logic [31:0] cpu_crit_data;
  logic        cpu_rd_valid = 1'b0;
  logic [2:0]  cpu_rd_off = '0;
  logic        cpu_rd_ready;
  logic [31:0] cpu_rd_data;
  logic        fill_done;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] q_addr[$];
  logic [31:0] q_data[$];

  always #5 clk = ~clk;

  cwf_line_fill u0 (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_crit_valid(cpu_crit_valid), .cpu_crit_data(cpu_crit_data),
    .cpu_rd_valid(cpu_rd_valid), .cpu_rd_off(cpu_rd_off),
    .cpu_rd_ready(cpu_rd_ready), .cpu_rd_data(cpu_rd_data),
    .fill_done(fill_done)
  );

  function automatic logic [31:0] dat(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: every data-array write is popped from the scoreboard (R4)
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (q_addr.size() == 0) begin
        chk(1'b0, "R4 unexpected write", {wr_addr, wr_data}, 48'h0);
      end else begin
        logic [15:0] ea;
        logic [31:0] ed;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        chk(wr_addr == ea && wr_data == ed, "R4 write slot/data", {wr_addr, wr_data}, {ea, ed});
      end
    end
  end

  task automatic run_fill(input logic [15:0] a, input int gap, input int req_wait, input int probe);
    logic [7:0] filled;
    logic [15:0] line;
    line = {a[15:3], 3'b000};
    filled = '0;
    @(posedge clk); #2;
    miss_valid = 1'b1; miss_addr = a;
    @(negedge clk);
    chk(miss_ready == 1'b1, "R1 ready when idle", {47'h0, miss_ready}, 48'h1);
    @(posedge clk); #2;
    miss_valid = 1'b0;
    @(negedge clk);
    chk(miss_ready == 1'b0, "R1 refused while busy", {47'h0, miss_ready}, 48'h0);
    chk(mem_req_valid && mem_req_addr == a, "R2 missed word requested",
        {mem_req_valid, mem_req_addr}, {1'b1, a});
    for (int w = 0; w < req_wait; w++) begin
      @(posedge clk); #2;
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == a, "R2 request held",
          {mem_req_valid, mem_req_addr}, {1'b1, a});
      chk(rd_ready == 1'b0, "R3 no beats before request", {47'h0, rd_ready}, 48'h0);
    end
    @(posedge clk); #2;
    mem_req_ready = 1'b1;
    @(posedge clk); #2;
    mem_req_ready = 1'b0;
    if (probe >= 0) begin
      cpu_rd_valid = 1'b1; cpu_rd_off = probe[2:0];
    end
    for (int k = 0; k < 8; k++) begin
      logic [2:0] off;
      off = a[2:0] + k[2:0];
      if (gap > 0 && (k % 2) == 1) begin
        rd_valid = 1'b0;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          chk(rd_ready == 1'b1, "R3 accepting during fill", {47'h0, rd_ready}, 48'h1);
          if (probe >= 0)
            chk(cpu_rd_ready == filled[probe], filled[probe] ? "R6 filled word served" : "R7 unfilled word stalls",
                {47'h0, cpu_rd_ready}, {47'h0, filled[probe]});
          @(posedge clk); #2;
        end
      end
      rd_valid = 1'b1;
      rd_data  = dat(line | {13'h0, off});
      q_addr.push_back(line | {13'h0, off});
      q_data.push_back(dat(line | {13'h0, off}));
      @(negedge clk);
      if (k == 0)
        chk(cpu_crit_valid && cpu_crit_data == dat(a), "R5 early return",
            {cpu_crit_valid, cpu_crit_data}, {1'b1, dat(a)});
      else
        chk(!cpu_crit_valid, "R5 only first beat", {47'h0, cpu_crit_valid}, 48'h0);
      chk(miss_ready == 1'b0, "R1 refused while busy", {47'h0, miss_ready}, 48'h0);
      if (probe >= 0) begin
        bit exp_rdy;
        exp_rdy = filled[probe] || (probe[2:0] == off);
        chk(cpu_rd_ready == exp_rdy, exp_rdy ? "R6 filled word served" : "R7 unfilled word stalls",
            {47'h0, cpu_rd_ready}, {47'h0, exp_rdy});
        if (exp_rdy)
          chk(cpu_rd_data == dat(line | {13'h0, probe[2:0]}), "R6 served data",
              {16'h0, cpu_rd_data}, {16'h0, dat(line | {13'h0, probe[2:0]})});
      end
      @(posedge clk);
      filled[off] = 1'b1;
      #2;
    end
    rd_valid = 1'b0;
    cpu_rd_valid = 1'b0;
    @(negedge clk);
    chk(fill_done == 1'b1, "R8 done after eighth write", {47'h0, fill_done}, 48'h1);
    chk(miss_ready == 1'b1, "R1 ready with done", {47'h0, miss_ready}, 48'h1);
    @(negedge clk);
    chk(fill_done == 1'b0, "R8 done single cycle", {47'h0, fill_done}, 48'h0);
    chk(q_addr.size() == 0, "R4 all eight slots written", {16'h0, 32'(q_addr.size())}, 48'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 48'h0, 48'h1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(miss_ready == 1'b1, "R9 reset miss_ready", {47'h0, miss_ready}, 48'h1);
    chk(!mem_req_valid && !rd_ready && !wr_en, "R9 reset outputs low",
        {45'h0, mem_req_valid, rd_ready, wr_en}, 48'h0);
    chk(!cpu_crit_valid && !cpu_rd_ready && !fill_done, "R9 reset pulses low",
        {45'h0, cpu_crit_valid, cpu_rd_ready, fill_done}, 48'h0);

    // stray beats and reads while idle are ignored (R3, R7)
    @(posedge clk); #2;
    rd_valid = 1'b1; rd_data = 32'hDEAD_BEEF;
    cpu_rd_valid = 1'b1; cpu_rd_off = 3'd2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!rd_ready && !wr_en, "R3 idle beat ignored", {46'h0, rd_ready, wr_en}, 48'h0);
      chk(!cpu_rd_ready, "R7 no service outside fill", {47'h0, cpu_rd_ready}, 48'h0);
      chk(miss_ready, "R3 idle beat leaves state", {47'h0, miss_ready}, 48'h1);
    end
    @(posedge clk); #2;
    rd_valid = 1'b0; cpu_rd_valid = 1'b0;

    run_fill(16'h0120, 0, 0, -1);   // aligned, back-to-back beats
    run_fill(16'h0345, 2, 1, 2);    // middle offset, gaps, probe wrapped word
    run_fill(16'h0F07, 1, 3, 0);    // last offset, every later beat wraps
    run_fill(16'h2203, 3, 0, 4);    // probe word arriving mid-fill
    run_fill(16'h2206, 0, 2, 6);    // probe the critical word itself

    repeat (3) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule